// File: doc/BRIEF.md
# Self-Timed Program-Memory Cycle Controller

This block is the control register that software uses to start erase and write cycles on a program-memory array. Software reads and writes one 8-bit register over a simple bus. Setting the start bit, with write enable present, begins a cycle of fixed length. The length is a parameter counted in clock cycles and stands in for the array's programming time. For the whole cycle the block holds a busy output and exactly one strobe, erase or write, chosen by the erase-select bit that was in force at launch.

Only software can set the start bit, and only hardware clears it, when the cycle ends. An erase cycle also clears the erase-select bit when it completes. An error flag records two events: a start attempted without write enable, and a warm reset that cuts a running cycle short. After either event the space-select bit keeps its value, so software can still see which space the failed operation targeted. A power-on reset clears everything.

Top module: `flash_seq_ctrl`

## Requirements
- R1: Register fields: bit 6 = target space (1 configuration, 0 program), bit 4 = erase select, bit 3 = error, bit 2 = write enable, bit 1 = start/busy. Bits 7, 5 and 0 always read 0.
- R2: A register write with bit 1 = 1 and bit 2 = 1 while idle launches a cycle. `busy` and read bit 1 are then high for exactly CYCLE_LEN clock cycles, starting at the launching edge.
- R3: While a cycle runs, writing 0 to bit 1 has no effect. The cycle runs to its full length.
- R4: During a cycle exactly one strobe is high. `erase_stb` is high if the erase-select bit was 1 at launch; otherwise `write_stb` is high. Both strobes are low when idle.
- R5: When an erase cycle completes, the hardware clears the erase-select bit. Write cycles leave the erase-select bit unchanged.
- R6: A cycle that completes normally leaves the error bit at 0 and the start bit at 0.
- R7: A write with bit 1 = 1 and bit 2 = 0 while idle starts no cycle and sets the error bit. The other fields take the written values.
- R8: A warm reset (`wrst_n` low at a clock edge) during a cycle aborts the cycle. It sets the error bit, clears start, erase select and write enable, and leaves the target-space bit unchanged.
- R9: A warm reset while idle clears start, erase select and write enable. It leaves the error bit and the target-space bit unchanged.
- R10: Register writes during a cycle do not change the erase-select or target-space bits.
- R11: Power-on reset (`por_n` low, asynchronous) clears every register bit, the error bit included, and drops busy and both strobes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| por_n | input | 1 | Power-on reset, asynchronous, active low |
| wrst_n | input | 1 | Warm reset, synchronous, active low |
| reg_we | input | 1 | Register write strobe |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read value |
| busy | output | 1 | Cycle in progress |
| erase_stb | output | 1 | Erase strobe toward the array |
| write_stb | output | 1 | Write strobe toward the array |
| cfg_space | output | 1 | Selected target space toward the array |

## Verification
The bench applies every 8-bit write value to an idle register after a power-on reset. For each value it works out whether a cycle should launch, an improper attempt should be flagged, or nothing should happen, and it times every launched cycle. Each of the following mistakes would show up as a wrong read-back value or a wrong cycle length:
- letting software clear the start bit;
- gating launch on the old write-enable bit instead of the written one;
- leaving erase select set after an erase;
- running the cycle one cycle short or long.

Directed sequences cover writes that arrive mid-cycle and try to move the space or erase bits or drop the start bit. They also cover warm resets during a cycle and while idle: a design that wiped the space bit or lost the error bit there would fail. A final power-on reset must clear a latched error.

// File: rtl/flashctl_pkg.sv
`timescale 1ns/1ps
package flashctl_pkg;
  localparam int B_CFG   = 6;
  localparam int B_ERASE = 4;
  localparam int B_ERR   = 3;
  localparam int B_WEN   = 2;
  localparam int B_GO    = 1;
  localparam logic [7:0] IMPL_MASK = 8'b0101_1110;

  typedef enum logic {MODE_WRITE = 1'b0, MODE_ERASE = 1'b1} op_mode_e;

  function automatic logic [7:0] pack_reg(input logic cfg, input logic erase,
                                          input logic err, input logic wen,
                                          input logic go);
    logic [7:0] r;
    r = 8'h00;
    r[B_CFG]   = cfg;
    r[B_ERASE] = erase;
    r[B_ERR]   = err;
    r[B_WEN]   = wen;
    r[B_GO]    = go;
    return r;
  endfunction

  function automatic logic wants_launch(input logic we, input logic go_bit,
                                        input logic wen_bit, input logic busy);
    return we & go_bit & wen_bit & ~busy;
  endfunction

  function automatic logic wants_improper(input logic we, input logic go_bit,
                                          input logic wen_bit, input logic busy);
    return we & go_bit & ~wen_bit & ~busy;
  endfunction
endpackage

// File: rtl/fc_cycle_timer.sv
`timescale 1ns/1ps
module fc_cycle_timer
  import flashctl_pkg::*;
#(
  parameter int CYCLE_LEN = 8,
  localparam int CNT_W = (CYCLE_LEN > 1) ? $clog2(CYCLE_LEN) : 1
) (
  input  logic clk,
  input  logic por_n,
  input  logic wrst_n,
  input  logic launch,
  input  logic launch_erase,
  output logic active,
  output logic done,
  output logic erase_stb,
  output logic write_stb
);
  logic [CNT_W-1:0] cnt_q;
  op_mode_e         mode_q;

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      active <= 1'b0;
      cnt_q  <= '0;
      mode_q <= MODE_WRITE;
    end else if (!wrst_n) begin
      active <= 1'b0;
      cnt_q  <= '0;
    end else if (launch) begin
      active <= 1'b1;
      cnt_q  <= CNT_W'(CYCLE_LEN - 1);
      mode_q <= launch_erase ? MODE_ERASE : MODE_WRITE;
    end else if (active) begin
      if (cnt_q == '0) active <= 1'b0;
      else             cnt_q  <= cnt_q - 1'b1;
    end
  end

  assign done      = active & (cnt_q == '0) & wrst_n;
  assign erase_stb = active & (mode_q == MODE_ERASE);
  assign write_stb = active & (mode_q == MODE_WRITE);
endmodule

// File: rtl/fc_ctrl_bits.sv
`timescale 1ns/1ps
module fc_ctrl_bits (
  input  logic clk,
  input  logic por_n,
  input  logic wrst_n,
  input  logic we,
  input  logic wd_cfg,
  input  logic wd_erase,
  input  logic wd_err,
  input  logic wd_wen,
  input  logic busy,
  input  logic done,
  input  logic done_erase,
  input  logic improper,
  output logic cfg_q,
  output logic erase_q,
  output logic err_q,
  output logic wen_q
);
  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      cfg_q   <= 1'b0;
      erase_q <= 1'b0;
      err_q   <= 1'b0;
      wen_q   <= 1'b0;
    end else if (!wrst_n) begin
      erase_q <= 1'b0;
      wen_q   <= 1'b0;
      if (busy) err_q <= 1'b1;
    end else begin
      if (we) begin
        wen_q <= wd_wen;
        err_q <= wd_err;
        if (!busy) begin
          cfg_q   <= wd_cfg;
          erase_q <= wd_erase;
        end
      end
      if (done) begin
        err_q <= 1'b0;
        if (done_erase) erase_q <= 1'b0;
      end
      if (improper) err_q <= 1'b1;
    end
  end
endmodule

// File: rtl/flash_seq_ctrl.sv
`timescale 1ns/1ps
module flash_seq_ctrl
  import flashctl_pkg::*;
#(
  parameter int CYCLE_LEN = 8
) (
  input  logic       clk,
  input  logic       por_n,
  input  logic       wrst_n,
  input  logic       reg_we,
  input  logic [7:0] reg_wdata,
  output logic [7:0] reg_rdata,
  output logic       busy,
  output logic       erase_stb,
  output logic       write_stb,
  output logic       cfg_space
);
  logic launch, improper, cyc_done;
  logic erase_q, err_q, wen_q;
  logic unused_wbits;

  assign unused_wbits = ^{reg_wdata[7], reg_wdata[5], reg_wdata[0]};

  assign launch   = wrst_n & wants_launch(reg_we, reg_wdata[B_GO], reg_wdata[B_WEN], busy);
  assign improper = wrst_n & wants_improper(reg_we, reg_wdata[B_GO], reg_wdata[B_WEN], busy);

  fc_cycle_timer #(.CYCLE_LEN(CYCLE_LEN)) u_timer (
    .clk          (clk),
    .por_n        (por_n),
    .wrst_n       (wrst_n),
    .launch       (launch),
    .launch_erase (reg_wdata[B_ERASE]),
    .active       (busy),
    .done         (cyc_done),
    .erase_stb    (erase_stb),
    .write_stb    (write_stb)
  );

  fc_ctrl_bits u_bits (
    .clk        (clk),
    .por_n      (por_n),
    .wrst_n     (wrst_n),
    .we         (reg_we),
    .wd_cfg     (reg_wdata[B_CFG]),
    .wd_erase   (reg_wdata[B_ERASE]),
    .wd_err     (reg_wdata[B_ERR]),
    .wd_wen     (reg_wdata[B_WEN]),
    .busy       (busy),
    .done       (cyc_done),
    .done_erase (erase_stb),
    .improper   (improper),
    .cfg_q      (cfg_space),
    .erase_q    (erase_q),
    .err_q      (err_q),
    .wen_q      (wen_q)
  );

  assign reg_rdata = pack_reg(cfg_space, erase_q, err_q, wen_q, busy);
endmodule

module fc_checker
  import flashctl_pkg::*;
#(
  parameter int CYCLE_LEN = 8
) (
  input logic       clk,
  input logic       por_n,
  input logic       wrst_n,
  input logic [7:0] reg_rdata,
  input logic       busy,
  input logic       erase_stb,
  input logic       write_stb,
  input logic       cfg_space,
  input logic       launch,
  input logic       improper,
  input logic       cyc_done
);
  int unsigned run_q;

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n)                run_q <= 0;
    else if (busy && wrst_n)   run_q <= run_q + 1;
    else                       run_q <= 0;
  end

  p_unimpl_r1: assert property (@(posedge clk) disable iff (!por_n)
    (reg_rdata & ~IMPL_MASK) == 8'h00);
  p_launch_r2: assert property (@(posedge clk) disable iff (!por_n)
    launch |=> busy && reg_rdata[B_GO]);
  p_len_r2: assert property (@(posedge clk) disable iff (!por_n)
    cyc_done |-> run_q == CYCLE_LEN - 1);
  p_hold_r3: assert property (@(posedge clk) disable iff (!por_n)
    busy && wrst_n && !cyc_done |=> busy);
  p_strobe_r4: assert property (@(posedge clk) disable iff (!por_n)
    ((erase_stb | write_stb) == busy) && !(erase_stb && write_stb));
  p_erase_clr_r5: assert property (@(posedge clk) disable iff (!por_n)
    cyc_done && erase_stb |=> !reg_rdata[B_ERASE]);
  p_done_r6: assert property (@(posedge clk) disable iff (!por_n)
    cyc_done |=> !reg_rdata[B_ERR] && !busy);
  p_improper_r7: assert property (@(posedge clk) disable iff (!por_n)
    improper |=> reg_rdata[B_ERR] && !busy);
  p_abort_r8: assert property (@(posedge clk) disable iff (!por_n)
    !wrst_n && busy |=> reg_rdata[B_ERR] && !busy && !reg_rdata[B_ERASE] && !reg_rdata[B_WEN]);
  p_warm_cfg_r8: assert property (@(posedge clk) disable iff (!por_n)
    !wrst_n |=> $stable(cfg_space));
  p_busy_fields_r10: assert property (@(posedge clk) disable iff (!por_n)
    busy && wrst_n && !cyc_done |=> $stable(reg_rdata[B_ERASE]) && $stable(cfg_space));
endmodule

bind flash_seq_ctrl fc_checker #(.CYCLE_LEN(CYCLE_LEN)) u_chk (
  .clk       (clk),
  .por_n     (por_n),
  .wrst_n    (wrst_n),
  .reg_rdata (reg_rdata),
  .busy      (busy),
  .erase_stb (erase_stb),
  .write_stb (write_stb),
  .cfg_space (cfg_space),
  .launch    (launch),
  .improper  (improper),
  .cyc_done  (cyc_done)
);

// File: tb/tb_flash_seq_ctrl.sv
`timescale 1ns/1ps
module tb_flash_seq_ctrl;
  localparam int CYC = 4;

  logic       clk = 1'b0;
  logic       por_n = 1'b0;
  logic       wrst_n = 1'b1;
  logic       reg_we = 1'b0;
  logic [7:0] reg_wdata = 8'h00;
  logic [7:0] reg_rdata;
  logic       busy, erase_stb, write_stb, cfg_space;

  int total = 0;
  int bad = 0;
  bit finished = 0;

  flash_seq_ctrl #(.CYCLE_LEN(CYC)) dut (
    .clk(clk), .por_n(por_n), .wrst_n(wrst_n), .reg_we(reg_we),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .busy(busy),
    .erase_stb(erase_stb), .write_stb(write_stb), .cfg_space(cfg_space)
  );

  always #5 clk = ~clk;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] expv(input logic cfg, input logic er, input logic err,
                                      input logic wen, input logic go);
    return {1'b0, cfg, 1'b0, er, err, wen, go, 1'b0};
  endfunction

  task automatic do_por();
    @(negedge clk) por_n = 1'b0;
    @(negedge clk) por_n = 1'b1;
  endtask

  task automatic do_write(input logic [7:0] v);
    @(negedge clk) begin reg_we = 1'b1; reg_wdata = v; end
    @(negedge clk) reg_we = 1'b0;
  endtask

  task automatic do_warm();
    @(negedge clk) wrst_n = 1'b0;
    @(negedge clk) wrst_n = 1'b1;
  endtask

  task automatic run_out(output int n);
    n = 0;
    while (busy && n < 50) begin
      n++;
      @(negedge clk);
    end
  endtask

  initial begin
    int n;
    repeat (2) @(negedge clk);
    por_n = 1'b1;
    check("R11 reset rdata", reg_rdata, 8'h00);
    check("R11 reset busy", {busy, erase_stb, write_stb}, 3'b000);

    for (int v = 0; v < 256; v++) begin
      logic [7:0] w;
      logic go, er, imp;
      w   = v[7:0];
      go  = w[1] & w[2];
      imp = w[1] & ~w[2];
      er  = w[4];
      do_por();
      if (v % 32 == 0) check("R11 por clears", reg_rdata, 8'h00);
      do_write(w);
      check(imp ? "R7 improper readback" : "R1 readback", reg_rdata,
            expv(w[6], w[4], imp ? 1'b1 : w[3], w[2], go));
      if (go) begin
        check("R4 strobes", {erase_stb, write_stb}, {er, ~er});
        run_out(n);
        check("R2 cycle length", n, CYC);
        check("R5 R6 after completion", reg_rdata, expv(w[6], 1'b0, 1'b0, w[2], 1'b0));
        check("R4 strobes idle", {erase_stb, write_stb}, 2'b00);
      end else begin
        check("R7 no cycle", {busy, erase_stb, write_stb}, 3'b000);
      end
    end

    // R3 / R10: writes during an erase cycle
    do_por();
    do_write(8'h16);
    check("R2 launch erase", {busy, erase_stb}, 2'b11);
    do_write(8'h44);
    check("R3 start held", busy, 1'b1);
    check("R10 fields held", reg_rdata, expv(1'b0, 1'b1, 1'b0, 1'b1, 1'b1));
    check("R4 erase strobe held", erase_stb, 1'b1);
    run_out(n);
    check("R3 full length", n, CYC - 2);
    check("R5 erase cleared", reg_rdata, expv(1'b0, 1'b0, 1'b0, 1'b1, 1'b0));

    // R5: write cycle leaves erase select (set after completion, not during)
    do_write(8'h06);
    run_out(n);
    check("R5 write leaves erase", reg_rdata, expv(1'b0, 1'b0, 1'b0, 1'b1, 1'b0));

    // R8: warm reset aborts a cycle
    do_por();
    do_write(8'h44);
    do_write(8'h56);
    check("R8 running", busy, 1'b1);
    do_warm();
    check("R8 abort readback", reg_rdata, 8'h48);
    check("R8 abort outputs", {busy, erase_stb, write_stb, cfg_space}, 4'b0001);

    // R9: warm reset while idle
    do_warm();
    check("R9 idle warm keeps err cfg", reg_rdata, 8'h48);
    do_write(8'h54);
    check("R9 setup", reg_rdata, expv(1'b1, 1'b1, 1'b0, 1'b1, 1'b0));
    do_warm();
    check("R9 idle warm clears", reg_rdata, expv(1'b1, 1'b0, 1'b0, 1'b0, 1'b0));

    // R6: launch with error already set clears it at completion
    do_write(8'h0E);
    check("R6 launch with err", reg_rdata, expv(1'b0, 1'b0, 1'b1, 1'b1, 1'b1));
    run_out(n);
    check("R6 err cleared", reg_rdata, expv(1'b0, 1'b0, 1'b0, 1'b1, 1'b0));

    // R11: power-on reset clears latched error
    do_write(8'h4A);
    check("R7 improper again", reg_rdata, 8'h48);
    do_por();
    check("R11 por clears err", reg_rdata, 8'h00);

    if (!finished) begin
      finished = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      total++;
      bad++;
      $display("FAIL watchdog act=hung exp=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule